// File: doc/BRIEF.md
# Calendar Update Cycle with Alarm

This block holds the running date and time of a real-time clock: seconds, minutes, hours, day of week, day of month, month and year. A 1 Hz enable starts each update cycle. The internal time counters advance at the start of the cycle, and the update-in-progress flag rises. The time registers seen by software change only after eight ticks of a 32 kHz enable have passed. In that same cycle the alarm compare and the update-ended event are evaluated, and the flag drops.

The control register inputs choose the encoding of the published bytes, either BCD or plain binary, and either 12-hour or 24-hour format. A freeze bit holds the published bytes still while software writes a new time. When the bit is released, the internal counters load from the written bytes. A host write to a time byte while the freeze bit is clear also loads the counters, in the following cycle. Address decode and the interrupt status register are outside this block. The block only emits a one-cycle mask that is to be ORed into that register.

Top module: `rtc_update_core`

## Requirements
- R1: An update cycle starts on `sec_tick` only when `ctrl_a[6:4]` is 3'b010. With any other value the second passes with no advance, no `uip` and no flag pulse.
- R2: At the clock edge that samples `sec_tick` (with freeze off), `uip` goes to 1. The published time bytes do not change until the update completes.
- R3: The update completes at the edge that samples the 8th `tick32` pulse after `sec_tick`. At that edge the time bytes are published, `uip` returns to 0, and `flag_set` carries a pulse that lasts exactly one cycle.
- R4: `ctrl_b[2]`=1 publishes binary values. `ctrl_b[2]`=0 publishes packed BCD (tens in bits 7:4, units in bits 3:0). Host-written bytes are decoded with the same rule.
- R5: `ctrl_b[1]`=1 selects 24-hour hours (0..23). When it is 0, hours show as 1..12, internal hour 0 shows as 12, and bit 7 of `reg_hour` is set when the internal hour is 12 or more.
- R6: Each field rolls over in turn: seconds at 60, minutes at 60, hours at 24, and day of week from 6 to 0. Day of month goes from the month's length back to 1, month goes from 12 back to 1, and `reg_year` holds the year modulo 100. The internal year is 2000 plus the loaded year byte.
- R7: February has 29 days when the year is a multiple of 4 and either not a multiple of 100 or a multiple of 400. Otherwise it has 28 days.
- R8: With `ctrl_b[5]`=1, the seconds, minutes and hours alarm bytes are each compared with the advanced time. A byte matches when its bits 7:6 are 2'b11 (wildcard) or when its decoded value equals the internal field (hour in 0..23). If all three match, 8'hA0 is ORed into `flag_set`.
- R9: With `ctrl_b[4]`=1, every completed update ORs 8'h90 into `flag_set`. The alarm and update-ended events still occur while the freeze bit is set.
- R10: While `ctrl_b[7]` (freeze) is set, `uip` is forced to 0 and no publishing takes place. One cycle after freeze is cleared, the internal time is reloaded from the time bytes.
- R11: A host write (`host_wr`, `host_idx` 0..6 = sec, min, hour, day of week, day of month, month, year) updates that byte at the next edge. When freeze is clear, the internal time is reloaded from the bytes one cycle later.
- R12: After reset the bytes read sec=min=hour=dow=year=8'h00 and dom=month=8'h01, with `uip`=0 and `flag_set`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_tick | input | 1 | 1 Hz enable pulse, one cycle wide |
| tick32 | input | 1 | 32 kHz enable pulse, one cycle wide |
| ctrl_a | input | 8 | Control A; bits 6:4 select oscillator state |
| ctrl_b | input | 8 | Control B; 7 freeze, 5 alarm enable, 4 update-ended enable, 2 binary, 1 24-hour |
| alarm_sec | input | 8 | Seconds alarm byte |
| alarm_min | input | 8 | Minutes alarm byte |
| alarm_hour | input | 8 | Hours alarm byte |
| host_wr | input | 1 | Host write strobe for a time byte |
| host_idx | input | 3 | Index of the time byte written |
| host_data | input | 8 | Data written |
| reg_sec | output | 8 | Published seconds |
| reg_min | output | 8 | Published minutes |
| reg_hour | output | 8 | Published hours |
| reg_dow | output | 8 | Published day of week |
| reg_dom | output | 8 | Published day of month |
| reg_mon | output | 8 | Published month |
| reg_year | output | 8 | Published year modulo 100 |
| uip | output | 1 | Update in progress |
| flag_set | output | 8 | One-cycle mask to be ORed into the status register |

## Verification
The bench targets several corner cases, each with a distinct failure mode:
- Chained rollovers end of day, month and year, including 2000, 2023 and 2024 February. A wrong leap rule gives March 1 in place of February 29, or the reverse.
- The 11:59:59 PM to 12 AM hour in 12-hour mode. A design that shows hour 0 as 0, or that misplaces the PM bit, fails here.
- The update window. Publishing one `tick32` early or late, or leaving `uip` high, shows up at the 7th and 8th ticks.
- Alarm wildcards, together with random mismatches. A design that ignores the wildcard bits, or that compares before the advance, misses the alarm or raises a spurious one.
- Freeze and host-write reloads. A design that keeps the time advanced during freeze, or that fails to reload on release, publishes the wrong second.

// File: rtl/rtc_update_core.sv
module rtc_update_core #(
  parameter int DELAY_TICKS = 8,
  parameter int CENTURY     = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sec_tick,
  input  logic       tick32,
  input  logic [7:0] ctrl_a,
  input  logic [7:0] ctrl_b,
  input  logic [7:0] alarm_sec,
  input  logic [7:0] alarm_min,
  input  logic [7:0] alarm_hour,
  input  logic       host_wr,
  input  logic [2:0] host_idx,
  input  logic [7:0] host_data,
  output logic [7:0] reg_sec,
  output logic [7:0] reg_min,
  output logic [7:0] reg_hour,
  output logic [7:0] reg_dow,
  output logic [7:0] reg_dom,
  output logic [7:0] reg_mon,
  output logic [7:0] reg_year,
  output logic       uip,
  output logic [7:0] flag_set
);
  localparam int CW = $clog2(DELAY_TICKS) + 1;

  function automatic logic [7:0] enc(input logic [6:0] v, input logic b);
    enc = b ? {1'b0, v} : {4'(v / 7'd10), 4'(v % 7'd10)};
  endfunction

  function automatic logic [7:0] dec(input logic [7:0] v, input logic b);
    dec = b ? v : 8'({4'd0, v[7:4]} * 8'd10 + {4'd0, v[3:0]});
  endfunction

  wire osc_ok   = ctrl_a[6:4] == 3'b010;
  wire freeze   = ctrl_b[7];
  wire aie      = ctrl_b[5];
  wire uie      = ctrl_b[4];
  wire bin      = ctrl_b[2];
  wire h24      = ctrl_b[1];
  wire unused_bits = ^{ctrl_a[7], ctrl_a[3:0], ctrl_b[6], ctrl_b[3], ctrl_b[0]};

  logic [7:0] t_sec, t_min, t_hour, t_dow, t_dom, t_mon, t_yr;
  logic [6:0] t_cen;
  logic [7:0] n_sec, n_min, n_hour, n_dow, n_dom, n_mon, n_yr;
  logic [6:0] n_cen;
  logic [7:0] dim;
  logic       pend, set_q, reload_q;
  logic [CW-1:0] cnt;

  wire start = sec_tick & osc_ok;
  wire fire  = pend & tick32 & (cnt == CW'(DELAY_TICKS - 1));
  wire leap  = (t_yr[1:0] == 2'b00) && ((t_yr != 8'd0) || (t_cen[1:0] == 2'b00));

  always_comb begin
    case (t_mon)
      8'd2:                      dim = leap ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11:   dim = 8'd30;
      default:                   dim = 8'd31;
    endcase
  end

  always_comb begin
    n_sec = t_sec + 8'd1; n_min = t_min; n_hour = t_hour; n_dow = t_dow;
    n_dom = t_dom; n_mon = t_mon; n_yr = t_yr; n_cen = t_cen;
    if (n_sec >= 8'd60) begin
      n_sec = 8'd0;
      n_min = t_min + 8'd1;
      if (n_min >= 8'd60) begin
        n_min  = 8'd0;
        n_hour = t_hour + 8'd1;
        if (n_hour >= 8'd24) begin
          n_hour = 8'd0;
          n_dow  = (t_dow + 8'd1 >= 8'd7) ? 8'd0 : t_dow + 8'd1;
          n_dom  = t_dom + 8'd1;
          if (n_dom > dim) begin
            n_dom = 8'd1;
            n_mon = t_mon + 8'd1;
            if (n_mon > 8'd12) begin
              n_mon = 8'd1;
              n_yr  = t_yr + 8'd1;
              if (n_yr >= 8'd100) begin
                n_yr  = 8'd0;
                n_cen = t_cen + 7'd1;
              end
            end
          end
        end
      end
    end
  end

  wire [7:0] hraw   = dec({1'b0, reg_hour[6:0]}, bin);
  wire [7:0] r_hour = h24 ? hraw : (hraw % 8'd12) + (reg_hour[7] ? 8'd12 : 8'd0);

  wire [7:0] h12    = (t_hour % 8'd12 == 8'd0) ? 8'd12 : t_hour % 8'd12;
  wire [7:0] p_hour = h24 ? enc(t_hour[6:0], bin)
                          : (enc(h12[6:0], bin) | {t_hour >= 8'd12, 7'd0});

  wire m_sec  = (alarm_sec[7:6]  == 2'b11) || (dec(alarm_sec, bin)  == t_sec);
  wire m_min  = (alarm_min[7:6]  == 2'b11) || (dec(alarm_min, bin)  == t_min);
  wire m_hour = (alarm_hour[7:6] == 2'b11) || (dec(alarm_hour, bin) == t_hour);
  wire alarm_hit = aie & m_sec & m_min & m_hour;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      set_q <= 1'b0; reload_q <= 1'b0; pend <= 1'b0; cnt <= '0; uip <= 1'b0;
      flag_set <= 8'd0;
    end else begin
      set_q    <= freeze;
      reload_q <= (host_wr & ~freeze) | (set_q & ~freeze);
      if (start) begin
        pend <= 1'b1; cnt <= '0;
      end else if (fire) begin
        pend <= 1'b0;
      end else if (pend & tick32) begin
        cnt <= cnt + CW'(1);
      end
      if (freeze)     uip <= 1'b0;
      else if (start) uip <= 1'b1;
      else if (fire)  uip <= 1'b0;
      flag_set <= fire ? {alarm_hit | uie, 1'b0, alarm_hit, uie, 4'd0} : 8'd0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_sec <= 8'd0; t_min <= 8'd0; t_hour <= 8'd0; t_dow <= 8'd0;
      t_dom <= 8'd1; t_mon <= 8'd1; t_yr <= 8'd0; t_cen <= 7'(CENTURY);
    end else if (reload_q) begin
      t_sec <= dec(reg_sec, bin); t_min <= dec(reg_min, bin); t_hour <= r_hour;
      t_dow <= dec(reg_dow, bin); t_dom <= dec(reg_dom, bin);
      t_mon <= dec(reg_mon, bin); t_yr <= dec(reg_year, bin); t_cen <= 7'(CENTURY);
    end else if (start) begin
      t_sec <= n_sec; t_min <= n_min; t_hour <= n_hour; t_dow <= n_dow;
      t_dom <= n_dom; t_mon <= n_mon; t_yr <= n_yr; t_cen <= n_cen;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_sec <= 8'h00; reg_min <= 8'h00; reg_hour <= 8'h00; reg_dow <= 8'h00;
      reg_dom <= 8'h01; reg_mon <= 8'h01; reg_year <= 8'h00;
    end else if (host_wr) begin
      case (host_idx)
        3'd0: reg_sec  <= host_data;
        3'd1: reg_min  <= host_data;
        3'd2: reg_hour <= host_data;
        3'd3: reg_dow  <= host_data;
        3'd4: reg_dom  <= host_data;
        3'd5: reg_mon  <= host_data;
        3'd6: reg_year <= host_data;
        default: ;
      endcase
    end else if (fire & ~freeze) begin
      reg_sec  <= enc(t_sec[6:0], bin);
      reg_min  <= enc(t_min[6:0], bin);
      reg_hour <= p_hour;
      reg_dow  <= enc(t_dow[6:0], bin);
      reg_dom  <= enc(t_dom[6:0], bin);
      reg_mon  <= enc(t_mon[6:0], bin);
      reg_year <= enc(t_yr[6:0], bin);
    end
  end

  a_r1_uip_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(uip) |-> ($past(sec_tick) && ($past(ctrl_a[6:4]) == 3'b010)));

  a_r10_freeze_drops_uip: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_b[7] |=> !uip);

  a_r3_flags_end_update: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_set != 8'd0) |-> (!uip && $past(pend)));

  a_r2_bytes_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(host_wr) && !$past(fire)) |->
      $stable({reg_sec, reg_min, reg_hour, reg_dow, reg_dom, reg_mon, reg_year}));

  a_r8_alarm_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    flag_set[5] |-> $past(ctrl_b[5]));

  a_r9_uf_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    flag_set[4] |-> $past(ctrl_b[4]));
endmodule

// File: tb/tb_rtc_update_core.sv
module tb_rtc_update_core;
  localparam int CLK_PERIOD = 10;
  localparam int DLY = 8;

  logic clk = 1'b0, rst_n = 1'b0, sec_tick = 1'b0, tick32 = 1'b0;
  logic [2:0] osc = 3'b010;
  logic set_b = 1'b0, aie = 1'b0, uie = 1'b0, bin = 1'b0, h24 = 1'b1;
  logic [7:0] alarm_sec = 8'h00, alarm_min = 8'h00, alarm_hour = 8'h00;
  logic host_wr = 1'b0;
  logic [2:0] host_idx = 3'd0;
  logic [7:0] host_data = 8'h00;
  logic [7:0] reg_sec, reg_min, reg_hour, reg_dow, reg_dom, reg_mon, reg_year, flag_set;
  logic uip;
  wire [7:0] ctrl_a = {1'b0, osc, 4'h6};
  wire [7:0] ctrl_b = {set_b, 1'b0, aie, uie, 1'b0, bin, h24, 1'b0};
  wire [55:0] regs = {reg_sec, reg_min, reg_hour, reg_dow, reg_dom, reg_mon, reg_year};

  int checks = 0, fails = 0;
  int ts, tm, th, tw, td, tmo, ty;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_update_core dut (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .tick32(tick32),
    .ctrl_a(ctrl_a), .ctrl_b(ctrl_b), .alarm_sec(alarm_sec), .alarm_min(alarm_min),
    .alarm_hour(alarm_hour), .host_wr(host_wr), .host_idx(host_idx), .host_data(host_data),
    .reg_sec(reg_sec), .reg_min(reg_min), .reg_hour(reg_hour), .reg_dow(reg_dow),
    .reg_dom(reg_dom), .reg_mon(reg_mon), .reg_year(reg_year), .uip(uip), .flag_set(flag_set));

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  function automatic logic [7:0] benc(int v);
    return bin ? 8'(v) : 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int bdec(logic [7:0] v);
    return bin ? int'(v) : int'(v[7:4]) * 10 + int'(v[3:0]);
  endfunction

  function automatic logic [7:0] bhour(int h);
    int k;
    if (h24) return benc(h);
    k = (h % 12 == 0) ? 12 : h % 12;
    return benc(k) | ((h >= 12) ? 8'h80 : 8'h00);
  endfunction

  function automatic int bdim(int m, int y);
    if (m == 2) return ((y % 4 == 0) && ((y % 100 != 0) || (y % 400 == 0))) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic logic [55:0] expect_regs();
    return {benc(ts), benc(tm), bhour(th), benc(tw), benc(td), benc(tmo), benc(ty % 100)};
  endfunction

  task automatic badvance();
    ts++;
    if (ts < 60) return;
    ts = 0; tm++;
    if (tm < 60) return;
    tm = 0; th++;
    if (th < 24) return;
    th = 0; tw = (tw + 1) % 7; td++;
    if (td <= bdim(tmo, ty)) return;
    td = 1; tmo++;
    if (tmo <= 12) return;
    tmo = 1; ty++;
  endtask

  task automatic hwrite(int idx, logic [7:0] d);
    host_wr = 1'b1; host_idx = 3'(idx); host_data = d;
    cyc();
    host_wr = 1'b0;
  endtask

  task automatic load_time(int s, int m, int h, int w, int d, int mo, int y);
    set_b = 1'b1; cyc();
    ts = s; tm = m; th = h; tw = w; td = d; tmo = mo; ty = y;
    hwrite(0, benc(s)); hwrite(1, benc(m)); hwrite(2, bhour(h)); hwrite(3, benc(w));
    hwrite(4, benc(d)); hwrite(5, benc(mo)); hwrite(6, benc(y % 100));
    set_b = 1'b0; cyc(); cyc(); cyc();
  endtask

  function automatic logic [7:0] pick_alarm(int v);
    case ($urandom % 4)
      0: return 8'hC0 | 8'($urandom % 64);
      1, 2: return benc(v);
      default: return benc(int'($urandom % 60));
    endcase
  endfunction

  task automatic one_second(string tag, bit run, bit rand_alarm);
    logic [55:0] prev, expr;
    logic [7:0] expf;
    bit hit;
    prev = regs;
    sec_tick = 1'b1; cyc(); sec_tick = 1'b0;
    chk("R2 uip after tick", {63'd0, uip}, {63'd0, run & ~set_b});
    if (run) badvance();
    if (rand_alarm) begin
      alarm_sec = pick_alarm(ts); alarm_min = pick_alarm(tm); alarm_hour = pick_alarm(th);
    end
    hit = ((alarm_sec[7:6] == 2'b11) || bdec(alarm_sec) == ts) &&
          ((alarm_min[7:6] == 2'b11) || bdec(alarm_min) == tm) &&
          ((alarm_hour[7:6] == 2'b11) || bdec(alarm_hour) == th);
    expf = 8'h00;
    if (run && aie && hit) expf |= 8'hA0;
    if (run && uie) expf |= 8'h90;
    expr = (run && !set_b) ? expect_regs() : prev;
    for (int i = 0; i < DLY; i++) begin
      tick32 = 1'b1; cyc(); tick32 = 1'b0;
      if (i == DLY - 2) begin
        chk("R2 bytes held in window", {8'd0, regs}, {8'd0, prev});
        chk("R2 uip held in window", {63'd0, uip}, {63'd0, run & ~set_b});
      end
      if (i == DLY - 1) begin
        chk({tag, " bytes published"}, {8'd0, regs}, {8'd0, expr});
        chk("R8 R9 flag mask", {56'd0, flag_set}, {56'd0, expf});
        chk("R3 uip cleared", {63'd0, uip}, 64'd0);
      end
      cyc();
    end
    chk("R3 flag pulse one cycle", {56'd0, flag_set}, 64'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [55:0] held;
    int sv[7];
    void'($urandom(32'd1234));
    cyc(); cyc(); rst_n = 1'b1; cyc();
    chk("R12 reset bytes", {8'd0, regs}, {8'd0, 56'h00_00_00_00_01_01_00});
    chk("R12 reset uip/flags", {55'd0, uip, flag_set}, 64'd0);

    // R7 leap years and R6 year rollover, BCD 24-hour
    load_time(59, 59, 23, 6, 28, 2, 2024); one_second("R7 2024 leap", 1, 0);
    load_time(59, 59, 23, 2, 28, 2, 2023); one_second("R7 2023 common", 1, 0);
    load_time(59, 59, 23, 1, 28, 2, 2000); one_second("R7 2000 leap", 1, 0);
    load_time(59, 59, 23, 6, 31, 12, 2099); one_second("R6 year wrap", 1, 0);
    load_time(59, 59, 23, 3, 30, 4, 2010); one_second("R6 month end", 1, 0);

    // R5 12-hour mode
    h24 = 1'b0;
    load_time(59, 59, 23, 4, 15, 6, 2031); one_second("R5 pm to 12am", 1, 0);
    chk("R5 midnight shows 12", {56'd0, reg_hour}, 64'h12);
    load_time(59, 59, 11, 4, 15, 6, 2031); one_second("R5 am to 12pm", 1, 0);
    chk("R5 noon with pm bit", {56'd0, reg_hour}, 64'h92);

    // R4 binary mode
    bin = 1'b1;
    load_time(59, 59, 23, 0, 31, 1, 2045); one_second("R4 binary 12h", 1, 0);
    h24 = 1'b1;
    load_time(58, 37, 19, 5, 9, 9, 2019); one_second("R4 binary 24h", 1, 0);
    chk("R4 binary seconds", {56'd0, reg_sec}, 64'd59);
    bin = 1'b0;

    // R8 alarm with wildcard, R9 update-ended
    aie = 1'b1; uie = 1'b1;
    load_time(14, 30, 8, 1, 3, 3, 2012);
    alarm_sec = 8'h15; alarm_min = 8'hC0; alarm_hour = 8'hFF;
    one_second("R8 wildcard alarm", 1, 0);
    alarm_sec = 8'h15;
    one_second("R8 mismatch", 1, 0);
    aie = 1'b0;
    one_second("R9 update ended only", 1, 0);
    uie = 1'b0;

    // R1 oscillator not running
    osc = 3'b000; held = regs;
    one_second("R1 osc stopped", 0, 0);
    chk("R1 bytes unchanged", {8'd0, regs}, {8'd0, held});
    osc = 3'b010;

    // R10 freeze clears uip, blocks publishing, reload on release
    load_time(30, 20, 10, 2, 5, 5, 2005);
    sv = '{ts, tm, th, tw, td, tmo, ty};
    held = regs;
    sec_tick = 1'b1; cyc(); sec_tick = 1'b0;
    chk("R10 uip before freeze", {63'd0, uip}, 64'd1);
    set_b = 1'b1; cyc();
    chk("R10 freeze clears uip", {63'd0, uip}, 64'd0);
    for (int i = 0; i < DLY; i++) begin
      tick32 = 1'b1; cyc(); tick32 = 1'b0; cyc();
    end
    chk("R10 no publish in freeze", {8'd0, regs}, {8'd0, held});
    uie = 1'b1;
    one_second("R10 frozen second", 1, 0);
    uie = 1'b0;
    set_b = 1'b0; cyc(); cyc(); cyc();
    ts = sv[0]; tm = sv[1]; th = sv[2]; tw = sv[3]; td = sv[4]; tmo = sv[5]; ty = sv[6];
    one_second("R10 reload after release", 1, 0);

    // R11 direct write with freeze clear
    hwrite(0, 8'h45); cyc(); cyc();
    ts = 45;
    one_second("R11 write reload", 1, 0);
    chk("R11 seconds after write", {56'd0, reg_sec}, 64'h46);

    // Random mix of R4 R5 R6 R8 R9
    for (int n = 0; n < 30; n++) begin
      int yy, mm, dd, nsec;
      bin = 1'($urandom); h24 = 1'($urandom); aie = 1'($urandom); uie = 1'($urandom);
      yy = 2000 + int'($urandom % 100);
      mm = 1 + int'($urandom % 12);
      dd = ($urandom % 3 == 0) ? bdim(mm, yy) : 1 + int'($urandom % bdim(mm, yy));
      load_time(($urandom % 2 == 0) ? 59 : int'($urandom % 60),
                ($urandom % 2 == 0) ? 59 : int'($urandom % 60),
                ($urandom % 2 == 0) ? 23 : int'($urandom % 24),
                int'($urandom % 7), dd, mm, yy);
      nsec = 1 + int'($urandom % 3);
      for (int k = 0; k < nsec; k++) one_second("R6 random", 1, 1);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule